// File: doc/BRIEF.md
# Load-Use Interlock and Bypass Controller

This block decides, every cycle, whether the instruction sitting in the second decode stage of a deep in-order, single-issue pipeline may move on to register read. Loads travel through fetch 1, fetch 2, decode 1, decode 2, register read, ALU, two data-memory stages and writeback. ALU operations skip the memory stages and write back the cycle after their ALU stage. The controller keeps a short record of every instruction in the back end: whether it is valid, whether it is a load, and which register it writes. It compares the decoding instruction's two source registers against that record.

When an operand would not be ready in time, the controller raises `stall`. The front end then holds the decoding instruction in place and freezes the stages behind it, while the controller places an empty slot into register read. When bypassing is built in (`BYPASS_EN`), it also gives each operand of the instruction now in the ALU stage a select code. This code picks between the register file, the result leaving the writeback stage and the result written back one cycle earlier. The number of memory stages is a parameter, and every stall distance follows from it.

Top module: `lu_interlock`

## Requirements
- R1: After reset no instruction is tracked: a valid decoding instruction is never stalled, `bubble` is 1 while `dec_valid` is 0, and both select codes are 0.
- R2: With bypassing off, an instruction reading a load's destination issues to register read no earlier than the cycle after that load's writeback: 4 stall cycles when it directly follows the load, one fewer for each cycle that separates them.
- R3: With bypassing off, an instruction reading an ALU result stalls 2 cycles when it directly follows the producer and 1 cycle when one instruction lies between them.
- R4: With bypassing on, an instruction reading a load result that directly follows the load stalls 2 cycles, and its select code for that operand is 1 in its ALU cycle.
- R5: With bypassing on, an instruction reading the result of the ALU instruction directly ahead of it does not stall, and its select code for that operand is 1.
- R6: With bypassing on, when the producer's writeback falls in the consumer's register-read cycle, the select code is 2. When the producer wrote back earlier than that, the code is 0.
- R7: `stall` is only ever 1 while `dec_valid` is 1. `bubble` is 1 in every cycle in which no instruction issues. Inserted empty slots never cause a stall or a forward.
- R8: When several tracked instructions write the same source register, only the youngest one decides the stall and the select code.
- R9: Register 0 as a source never stalls and is never forwarded, even right after an instruction that names register 0 as its destination.
- R10: Select code encoding per operand: 0 register file, 1 result leaving the writeback stage, 2 result written back in the previous cycle; 3 is never driven. A non-zero code appears only in the ALU cycle of an instruction, two cycles after the cycle in which it issued from decode. Both codes are always 0 when bypassing is off.
- R11: An instruction whose sources match no tracked destination issues without stalling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | A real instruction sits in the second decode stage |
| dec_src_a | input | 5 | First source register of the decoding instruction |
| dec_src_b | input | 5 | Second source register of the decoding instruction |
| dec_dst | input | 5 | Destination register of the decoding instruction (0 means none) |
| dec_is_load | input | 1 | The decoding instruction is a load |
| stall | output | 1 | Hold decode and freeze the front end this cycle |
| bubble | output | 1 | Register read receives an empty slot next cycle |
| fwd_sel_a | output | 2 | Source select for operand A of the instruction in the ALU stage |
| fwd_sel_b | output | 2 | Source select for operand B of the instruction in the ALU stage |

## Verification
A single instruction stream is run twice, once against an instance with bypassing and once against an instance without it. The stream contains back-to-back load-use and ALU-use pairs, one-instruction gaps, writes to register 0, and a register written first by an ALU instruction and then by a load. The load-use and ALU-use pairs separate the 4/2 and 2/0 stall distances of the two builds. The gaps separate the writeback-stage path from the retired-result path. The double write shows whether the youngest producer wins. Further directed sequences insert an idle decode slot between a load and its user, apply reset while a load is in flight, and present dependent registers while decode is empty.

// File: rtl/lu_pkg.sv
package lu_pkg;

    // Architectural register index width (32 registers).
    localparam int REG_W = 5;

    // Source operands compared per decoding instruction.
    localparam int OPS = 2;

    // Age at which an ALU-type producer sits in writeback (RR = age 0).
    localparam int ALU_WB_AGE = 2;

    // Cycles from the decode decision to the consumer's ALU stage.
    localparam int EX_LEAD = 2;

    typedef logic [REG_W-1:0] reg_idx_t;

    // Operand source select, as seen by the ALU-stage operand muxes.
    typedef enum logic [1:0] {
        FWD_RF  = 2'd0,
        FWD_WB  = 2'd1,
        FWD_RET = 2'd2
    } fwd_sel_e;

    // One in-flight instruction in the back end.
    typedef struct packed {
        logic     valid;
        logic     is_load;
        reg_idx_t dst;
    } flight_t;

    // Age (cycles after entering register read) at which a producer writes back.
    function automatic int wb_age(input logic is_load, input int mem_stages);
        return is_load ? (ALU_WB_AGE + mem_stages) : ALU_WB_AGE;
    endfunction

endpackage

// File: rtl/lu_tracker.sv
module lu_tracker
    import lu_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   issue,
    input  logic                   dec_is_load,
    input  reg_idx_t               dec_dst,
    output flight_t [DEPTH-1:0]    flights
);

    // Slot 0 is the register-read stage; slot i holds the instruction that
    // entered register read i cycles ago. An empty issue slot is invalid.
    always_ff @(posedge clk) begin
        if (rst) begin
            flights <= '0;
        end else begin
            if (issue) begin
                flights[0].valid   <= 1'b1;
                flights[0].is_load <= dec_is_load;
                flights[0].dst     <= dec_dst;
            end else begin
                flights[0] <= '0;
            end
            for (int i = 1; i < DEPTH; i++) begin
                flights[i] <= flights[i-1];
            end
        end
    end

endmodule

// File: rtl/lu_operand.sv
module lu_operand
    import lu_pkg::*;
#(
    parameter int DEPTH      = 4,
    parameter int MEM_STAGES = 2,
    parameter bit BYPASS_EN  = 1'b1
) (
    input  reg_idx_t             src,
    input  flight_t [DEPTH-1:0]  flights,
    output logic                 need_stall,
    output fwd_sel_e             sel
);

    logic hit;
    logic hit_load;
    int   hit_age;
    int   ready_age;

    // Scan oldest to youngest so the youngest matching producer wins.
    always_comb begin
        hit      = 1'b0;
        hit_load = 1'b0;
        hit_age  = 0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (flights[i].valid && (src != '0) && (flights[i].dst == src)) begin
                hit      = 1'b1;
                hit_load = flights[i].is_load;
                hit_age  = i;
            end
        end
        ready_age = wb_age(hit_load, MEM_STAGES);
    end

    generate
        if (BYPASS_EN) begin : g_bypass
            // Value must be at or past writeback when the consumer reaches ALU.
            always_comb begin
                need_stall = hit && ((hit_age + EX_LEAD) < ready_age);
                sel        = FWD_RF;
                if (hit) begin
                    if ((hit_age + EX_LEAD) == ready_age) begin
                        sel = FWD_WB;
                    end else if ((hit_age + EX_LEAD) == (ready_age + 1)) begin
                        sel = FWD_RET;
                    end
                end
            end
        end else begin : g_no_bypass
            // Consumer's register read must fall after the producer's writeback.
            always_comb begin
                need_stall = hit && (hit_age < ready_age);
                sel        = FWD_RF;
            end
        end
    endgenerate

endmodule

// File: rtl/lu_sel_pipe.sv
module lu_sel_pipe
    import lu_pkg::*;
#(
    parameter int N = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 issue,
    input  fwd_sel_e [N-1:0]     sel_dec,
    output fwd_sel_e [N-1:0]     sel_ex
);

    fwd_sel_e [N-1:0] sel_rr;

    // Codes follow their instruction: decode -> register read -> ALU.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < N; k++) begin
                sel_rr[k] <= FWD_RF;
                sel_ex[k] <= FWD_RF;
            end
        end else begin
            for (int k = 0; k < N; k++) begin
                sel_rr[k] <= issue ? sel_dec[k] : FWD_RF;
            end
            sel_ex <= sel_rr;
        end
    end

endmodule

// File: rtl/lu_interlock.sv
module lu_interlock
    import lu_pkg::*;
#(
    parameter int MEM_STAGES = 2,
    parameter bit BYPASS_EN  = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dec_valid,
    input  logic [REG_W-1:0] dec_src_a,
    input  logic [REG_W-1:0] dec_src_b,
    input  logic [REG_W-1:0] dec_dst,
    input  logic             dec_is_load,
    output logic             stall,
    output logic             bubble,
    output logic [1:0]       fwd_sel_a,
    output logic [1:0]       fwd_sel_b
);

    // Track every producer until the latest age that can still matter.
    localparam int DEPTH = ALU_WB_AGE + MEM_STAGES;

    flight_t  [DEPTH-1:0] flights;
    reg_idx_t [OPS-1:0]   op_src;
    logic     [OPS-1:0]   op_stall;
    fwd_sel_e [OPS-1:0]   op_sel;
    fwd_sel_e [OPS-1:0]   ex_sel;
    logic                 issue;

    assign op_src[0] = dec_src_a;
    assign op_src[1] = dec_src_b;

    lu_tracker #(.DEPTH(DEPTH)) u_tracker (
        .clk         (clk),
        .rst         (rst),
        .issue       (issue),
        .dec_is_load (dec_is_load),
        .dec_dst     (dec_dst),
        .flights     (flights)
    );

    generate
        for (genvar k = 0; k < OPS; k++) begin : g_op
            lu_operand #(
                .DEPTH      (DEPTH),
                .MEM_STAGES (MEM_STAGES),
                .BYPASS_EN  (BYPASS_EN)
            ) u_operand (
                .src        (op_src[k]),
                .flights    (flights),
                .need_stall (op_stall[k]),
                .sel        (op_sel[k])
            );
        end
    endgenerate

    assign stall  = dec_valid && (|op_stall);
    assign issue  = dec_valid && !stall;
    assign bubble = !issue;

    lu_sel_pipe #(.N(OPS)) u_sel_pipe (
        .clk     (clk),
        .rst     (rst),
        .issue   (issue),
        .sel_dec (op_sel),
        .sel_ex  (ex_sel)
    );

    assign fwd_sel_a = ex_sel[0];
    assign fwd_sel_b = ex_sel[1];

endmodule

// File: rtl/lu_interlock_chk.sv
module lu_interlock_chk
    import lu_pkg::*;
#(
    parameter bit BYPASS_EN = 1'b1
) (
    input logic             clk,
    input logic             rst,
    input logic             dec_valid,
    input logic [REG_W-1:0] dec_src_a,
    input logic [REG_W-1:0] dec_src_b,
    input logic [REG_W-1:0] dec_dst,
    input logic             dec_is_load,
    input logic             stall,
    input logic             bubble,
    input logic [1:0]       fwd_sel_a,
    input logic [1:0]       fwd_sel_b
);

    logic issued;
    assign issued = dec_valid && !stall;

    assert_stall_needs_valid_R7: assert property (@(posedge clk) disable iff (rst)
        stall |-> (dec_valid && bubble));

    assert_zero_src_R9: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_src_a == '0 && dec_src_b == '0) |-> !stall);

    assert_load_use_stall_R2: assert property (@(posedge clk) disable iff (rst)
        ($past(issued && dec_is_load && dec_dst != '0) && dec_valid
         && dec_src_a == $past(dec_dst)) |-> stall);

    assert_sel_legal_R10: assert property (@(posedge clk) disable iff (rst)
        (fwd_sel_a != 2'd3) && (fwd_sel_b != 2'd3));

    assert_sel_follows_issue_R10: assert property (@(posedge clk) disable iff (rst)
        ((fwd_sel_a != 2'd0) || (fwd_sel_b != 2'd0)) |-> $past(issued, 2));

    generate
        if (BYPASS_EN) begin : g_byp_chk
            assert_alu_chain_free_R5: assert property (@(posedge clk) disable iff (rst)
                ($past(issued && !dec_is_load && dec_dst != '0) && dec_valid
                 && dec_src_a == $past(dec_dst) && dec_src_b == '0) |-> !stall);
        end else begin : g_nobyp_chk
            assert_no_forward_R10: assert property (@(posedge clk) disable iff (rst)
                (fwd_sel_a == 2'd0) && (fwd_sel_b == 2'd0));
        end
    endgenerate

endmodule

bind lu_interlock lu_interlock_chk #(.BYPASS_EN(BYPASS_EN)) u_lu_interlock_chk (
    .clk         (clk),
    .rst         (rst),
    .dec_valid   (dec_valid),
    .dec_src_a   (dec_src_a),
    .dec_src_b   (dec_src_b),
    .dec_dst     (dec_dst),
    .dec_is_load (dec_is_load),
    .stall       (stall),
    .bubble      (bubble),
    .fwd_sel_a   (fwd_sel_a),
    .fwd_sel_b   (fwd_sel_b)
);

// File: tb/lu_interlock_bench.sv
module lu_interlock_bench;
    import lu_pkg::*;

    timeunit 1ns;
    timeprecision 100ps;

    localparam int MEM = 2;
    localparam int NPROG = 10;

    typedef struct packed {
        logic       ld;
        logic [4:0] dst;
        logic [4:0] sa;
        logic [4:0] sb;
        logic [3:0] st_byp;
        logic [3:0] st_nb;
    } prog_t;

    // ld, dst, src a, src b, expected stalls with bypass, without bypass
    localparam prog_t PROG [NPROG] = '{
        '{1'b1, 5'd1,  5'd2,  5'd0,  4'd0, 4'd0},  // R11 no producer
        '{1'b0, 5'd3,  5'd1,  5'd4,  4'd2, 4'd4},  // R2 R4 load-use
        '{1'b0, 5'd5,  5'd3,  5'd3,  4'd0, 4'd2},  // R3 R5 ALU chain
        '{1'b0, 5'd6,  5'd0,  5'd7,  4'd0, 4'd0},  // R9 R11 independent
        '{1'b0, 5'd8,  5'd5,  5'd0,  4'd0, 4'd1},  // R3 R6 one-slot gap
        '{1'b1, 5'd0,  5'd8,  5'd0,  4'd0, 4'd2},  // load writing register 0
        '{1'b0, 5'd9,  5'd0,  5'd0,  4'd0, 4'd0},  // R9 reads register 0
        '{1'b1, 5'd9,  5'd6,  5'd0,  4'd0, 4'd0},  // second writer of r9
        '{1'b0, 5'd10, 5'd9,  5'd9,  4'd2, 4'd4},  // R8 youngest is the load
        '{1'b0, 5'd11, 5'd10, 5'd9,  4'd0, 4'd2}   // R5 R6 mixed paths
    };

    logic       clk = 1'b0;
    logic       rst;
    logic       dv;
    logic [4:0] sa, sb, dd;
    logic       ld;
    logic       stall_b, bubble_b, stall_n, bubble_n;
    logic [1:0] fa_b, fb_b, fa_n, fb_n;

    int checks = 0;
    int errors = 0;
    int mode   = 1;
    int t      = 0;
    int prod_rr [32];
    bit prod_ld [32];
    int exp_a [4];
    int exp_b [4];

    always #2.5 clk = ~clk;

    lu_interlock #(.MEM_STAGES(MEM), .BYPASS_EN(1'b1)) u_lu_interlock (
        .clk(clk), .rst(rst), .dec_valid(dv), .dec_src_a(sa), .dec_src_b(sb),
        .dec_dst(dd), .dec_is_load(ld), .stall(stall_b), .bubble(bubble_b),
        .fwd_sel_a(fa_b), .fwd_sel_b(fb_b)
    );

    lu_interlock #(.MEM_STAGES(MEM), .BYPASS_EN(1'b0)) u_lu_interlock_nb (
        .clk(clk), .rst(rst), .dec_valid(dv), .dec_src_a(sa), .dec_src_b(sb),
        .dec_dst(dd), .dec_is_load(ld), .stall(stall_n), .bubble(bubble_n),
        .fwd_sel_a(fa_n), .fwd_sel_b(fb_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s t=%0d mode=%0d actual=%0d expected=%0d", req, t, mode, act, exp);
        end
    endtask

    function automatic int ready_of(input bit is_ld);
        return is_ld ? (2 + MEM) : 2;
    endfunction

    function automatic bit src_ok(input logic [4:0] r);
        if (r == 5'd0) return 1'b1;
        if (mode != 0) return (t + 2) >= (prod_rr[r] + ready_of(prod_ld[r]));
        return (t + 1) > (prod_rr[r] + ready_of(prod_ld[r]));
    endfunction

    function automatic int src_code(input logic [4:0] r);
        int g;
        if (r == 5'd0 || mode == 0) return 0;
        g = t + 2 - prod_rr[r];
        if (g == ready_of(prod_ld[r])) return 1;
        if (g == ready_of(prod_ld[r]) + 1) return 2;
        return 0;
    endfunction

    function automatic string code_req(input int c);
        if (c == 1) return "R5";
        if (c == 2) return "R6";
        return "R10";
    endfunction

    // Called at a falling edge: compare outputs with the scoreboard.
    task automatic cycle_eval(output bit issued);
        int  slot;
        int  ca, cb;
        bit  es;
        logic st, bu;
        logic [1:0] oa, ob;
        st = (mode != 0) ? stall_b  : stall_n;
        bu = (mode != 0) ? bubble_b : bubble_n;
        oa = (mode != 0) ? fa_b     : fa_n;
        ob = (mode != 0) ? fb_b     : fb_n;
        slot = t % 4;
        check(int'(oa) == exp_a[slot], code_req(exp_a[slot]), int'(oa), exp_a[slot]);
        check(int'(ob) == exp_b[slot], code_req(exp_b[slot]), int'(ob), exp_b[slot]);
        exp_a[slot] = 0;
        exp_b[slot] = 0;
        es = dv && !(src_ok(sa) && src_ok(sb));
        check(st == es, (mode != 0) ? "R4" : "R2", int'(st), int'(es));
        check(bu == (!dv || es), "R7", int'(bu), int'(!dv || es));
        issued = dv && !es;
        if (issued) begin
            ca = src_code(sa);
            cb = src_code(sb);
            exp_a[(t + 2) % 4] = ca;
            exp_b[(t + 2) % 4] = cb;
            if (dd != 5'd0) begin
                prod_rr[dd] = t + 1;
                prod_ld[dd] = ld;
            end
        end
    endtask

    task automatic advance();
        @(posedge clk);
        #1;
        t++;
    endtask

    task automatic run_instr(input prog_t ins, output int stalls);
        bit iss;
        dv = 1'b1; ld = ins.ld; dd = ins.dst; sa = ins.sa; sb = ins.sb;
        stalls = 0;
        iss = 1'b0;
        while (!iss) begin
            @(negedge clk);
            cycle_eval(iss);
            if (!iss) stalls++;
            advance();
        end
    endtask

    task automatic idle(input int n);
        bit iss;
        dv = 1'b0; ld = 1'b0; dd = 5'd0; sa = 5'd0; sb = 5'd0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cycle_eval(iss);
            advance();
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        dv = 1'b0; ld = 1'b0; dd = 5'd0; sa = 5'd0; sb = 5'd0;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        t = 0;
        for (int r = 0; r < 32; r++) begin
            prod_rr[r] = -1000;
            prod_ld[r] = 1'b0;
        end
        for (int s = 0; s < 4; s++) begin
            exp_a[s] = 0;
            exp_b[s] = 0;
        end
    endtask

    function automatic prog_t mk(input logic l, input logic [4:0] d,
                                 input logic [4:0] a, input logic [4:0] b);
        prog_t p;
        p = '{l, d, a, b, 4'd0, 4'd0};
        return p;
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        rst = 1'b1;
        dv = 1'b0; ld = 1'b0; dd = 5'd0; sa = 5'd0; sb = 5'd0;

        for (int m = 1; m >= 0; m--) begin
            mode = m;
            do_reset();

            // R1: empty state right after reset
            @(negedge clk);
            check(((m != 0) ? bubble_b : bubble_n) == 1'b1, "R1", 0, 1);
            check(((m != 0) ? stall_b : stall_n) == 1'b0, "R1", 1, 0);
            check(((m != 0) ? (fa_b | fb_b) : (fa_n | fb_n)) == 2'd0, "R1", 1, 0);
            advance();

            // Program table, one loop
            for (int i = 0; i < NPROG; i++) begin
                run_instr(PROG[i], n);
                check(n == int'((m != 0) ? PROG[i].st_byp : PROG[i].st_nb),
                      "table", n, int'((m != 0) ? PROG[i].st_byp : PROG[i].st_nb));
            end
            idle(4);

            // R2 R4: one empty decode slot between a load and its user
            run_instr(mk(1'b1, 5'd20, 5'd0, 5'd0), n);
            idle(1);
            run_instr(mk(1'b0, 5'd21, 5'd20, 5'd0), n);
            check(n == ((m != 0) ? 1 : 3), (m != 0) ? "R4" : "R2", n, (m != 0) ? 1 : 3);

            // R7: inserted empty slots behind a stall must not be producers
            run_instr(mk(1'b1, 5'd22, 5'd0, 5'd0), n);
            run_instr(mk(1'b0, 5'd23, 5'd22, 5'd0), n);
            run_instr(mk(1'b0, 5'd24, 5'd23, 5'd23), n);
            check(n == ((m != 0) ? 0 : 2), "R7", n, (m != 0) ? 0 : 2);

            // R11: sources unrelated to anything in flight
            run_instr(mk(1'b1, 5'd25, 5'd0, 5'd0), n);
            run_instr(mk(1'b0, 5'd26, 5'd27, 5'd28), n);
            check(n == 0, "R11", n, 0);
            idle(4);
        end

        // R1: reset while a load is in flight clears its record
        mode = 1;
        do_reset();
        run_instr(mk(1'b1, 5'd12, 5'd0, 5'd0), n);
        do_reset();
        run_instr(mk(1'b0, 5'd13, 5'd12, 5'd12), n);
        check(n == 0, "R1", n, 0);
        idle(4);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule